// File: doc/BRIEF.md
# Loss-of-Clock Bus Cycle Terminator

This block protects a host register interface whose timing is normally derived from a 44.736 MHz line-rate clock. That clock can come from either of two sources: the transmit input clock or the receive line clock. If both sources stop, the interface logic freezes, and a host read or write that is already under way would wait forever for its ready/acknowledge. The block runs from a free-running monitor clock, which takes the place of an on-chip oscillator. In that domain it watches both line clocks for transitions.

Each watched clock toggles a flag in its own domain. A two-flop synchronizer carries each flag into the monitor domain, and any change in the synchronized value counts as one edge. A saturating idle counter measures how long both clocks have been quiet. When neither clock has produced an edge for `LIMIT` monitor cycles, the block declares a loss of clock. If protection is enabled in the control register, it then ORs a forced ready into the host ready path while chip select is active, so the stalled cycle completes. Any edge on either clock clears the loss and returns the ready path to normal.

Top module: `clkloss_bus_guard`

## Requirements
- R1: After reset, protection is disabled, `loss_status` is 0 and `host_rdy_out` equals `host_rdy_in`.
- R2: With no transition on either watched clock, `loss_status` rises on exactly the `LIMIT`-th monitor rising edge after reset release, or after the idle count restarts (default `LIMIT` = 16).
- R3: While either clock alone produces an edge more often than once per `LIMIT` monitor cycles, `loss_status` stays 0.
- R4: The synchronizer path is two flops plus one detection stage. A rising edge on either watched clock therefore restarts the idle count: `loss_status` is 0 from the third monitor rising edge after that clock edge. It rises again `LIMIT` monitor edges after that third edge if the clocks stay quiet.
- R5: A write with `cfg_addr` = 8'h01 loads the protection enable from `cfg_wdata` bit 7 (1 enables, 0 disables). The other data bits have no effect.
- R6: A write to any other address leaves the protection enable unchanged.
- R7: With protection enabled, `loss_status` = 1 and `host_cs_n` = 0, `host_rdy_out` is 1.
- R8: The forced ready is present only while `host_cs_n` = 0. It is released when chip select goes high, and a new cycle during a continuing loss is forced again.
- R9: With protection disabled, the block never drives ready: `host_rdy_out` equals `host_rdy_in` even during a loss.
- R10: `host_rdy_in` = 1 always yields `host_rdy_out` = 1 (the normal ready path is never blocked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| tx_clk | input | 1 | Watched transmit input clock |
| rx_clk | input | 1 | Watched receive line clock |
| cfg_we | input | 1 | Control register write strobe (monitor domain) |
| cfg_addr | input | AW | Control register write address |
| cfg_wdata | input | DW | Control register write data |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rdy_in | input | 1 | Normal ready/acknowledge from the interface |
| host_rdy_out | output | 1 | Ready/acknowledge driven to the host |
| loss_status | output | 1 | Current loss-of-clock condition |

## Verification
The bench sweeps the loss onset cycle by cycle after reset and after a single edge on each clock. A timer that is off by one, or a synchronizer with the wrong depth, shows up as the flag moving one cycle early or late. It runs each clock alone to catch a design that requires both clocks to be active, which would falsely declare a loss. It then sweeps every combination of enable, loss, chip select and normal ready. That sweep exposes forcing while idle, forcing while disabled, and masking of the normal ready. Control writes to the wrong address, or with bit 7 clear and the other bits set, expose a decoder that loads the enable from the wrong place.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  // Control register location and the bit that holds the protection enable.
  localparam int unsigned CTRL_ADDR = 32'h01;
  localparam int unsigned EN_BIT    = 7;

  // Next idle count: restart on any edge, otherwise count up to the limit.
  function automatic int unsigned idle_next(input int unsigned cnt,
                                            input bit          any_edge,
                                            input int unsigned limit);
    if (any_edge)          return 0;
    else if (cnt >= limit) return limit;
    else                   return cnt + 1;
  endfunction

  // Forced ready term: only for an enabled guard, a lost clock and a live cycle.
  function automatic bit force_term(input bit en, input bit loss, input bit cs_act);
    return en & loss & cs_act;
  endfunction

endpackage

// File: rtl/clkloss_edge_sync.sv
module clkloss_edge_sync (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic src_clk,
  output logic edge_seen
);

  logic tgl_q;
  logic s1_q, s2_q, s3_q;

  // Toggle flag in the watched domain: flips on every rising edge.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= ~tgl_q;
  end

  // Two-flop synchronizer plus history stage in the monitor domain.
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_q;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_seen = s2_q ^ s3_q;

endmodule

// File: rtl/clkloss_timer.sv
module clkloss_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic mon_clk,
  input  logic rst_n,
  input  logic any_edge,
  output logic loss
);
  import clkloss_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = CW'(idle_next(32'(cnt_q), any_edge, LIMIT));
  end

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign loss = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/clkloss_ctrl.sv
module clkloss_ctrl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          mon_clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          prot_en
);
  import clkloss_pkg::*;

  logic hit;
  logic unused_wbits;

  assign hit = cfg_we && (cfg_addr == AW'(CTRL_ADDR));
  assign unused_wbits = ^(cfg_wdata & ~(DW'(1) << EN_BIT));

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)   prot_en <= 1'b0;
    else if (hit) prot_en <= cfg_wdata[EN_BIT];
  end

endmodule

// File: rtl/clkloss_bus_guard.sv
module clkloss_bus_guard #(
  parameter int unsigned LIMIT = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          mon_clk,
  input  logic          rst_n,
  input  logic          tx_clk,
  input  logic          rx_clk,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          host_cs_n,
  input  logic          host_rdy_in,
  output logic          host_rdy_out,
  output logic          loss_status
);
  import clkloss_pkg::*;

  localparam int unsigned NCLK = 2;

  logic [NCLK-1:0] watched;
  logic [NCLK-1:0] edge_vec;
  logic            any_edge;
  logic            loss;
  logic            prot_en;
  logic            cs_act;
  logic            force_rdy;

  assign watched = {rx_clk, tx_clk};

  for (genvar g = 0; g < NCLK; g++) begin : g_watch
    clkloss_edge_sync u_sync (
      .mon_clk  (mon_clk),
      .rst_n    (rst_n),
      .src_clk  (watched[g]),
      .edge_seen(edge_vec[g])
    );
  end

  assign any_edge = |edge_vec;

  clkloss_timer #(.LIMIT(LIMIT)) u_timer (
    .mon_clk (mon_clk),
    .rst_n   (rst_n),
    .any_edge(any_edge),
    .loss    (loss)
  );

  clkloss_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .mon_clk  (mon_clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .prot_en  (prot_en)
  );

  assign cs_act       = ~host_cs_n;
  assign force_rdy    = force_term(prot_en, loss, cs_act);
  assign host_rdy_out = host_rdy_in | force_rdy;
  assign loss_status  = loss;

endmodule

// File: rtl/clkloss_bus_guard_chk.sv
module clkloss_bus_guard_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input logic          mon_clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          host_cs_n,
  input logic          host_rdy_in,
  input logic          host_rdy_out,
  input logic          loss_status,
  input logic          any_edge,
  input logic          prot_en
);

  AST_RDY_PASS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    host_rdy_in |-> host_rdy_out); // R10
  AST_NO_FORCE_DISABLED: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (!prot_en && !host_rdy_in) |-> !host_rdy_out); // R9
  AST_NO_FORCE_IDLE: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (host_cs_n && !host_rdy_in) |-> !host_rdy_out); // R8
  AST_FORCE_ON_LOSS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (prot_en && loss_status && !host_cs_n) |-> host_rdy_out); // R7
  AST_LOSS_CLEARS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    any_edge |=> !loss_status); // R4
  AST_LOSS_HOLDS: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (loss_status && !any_edge) |=> loss_status); // R2
  AST_EN_LOAD: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(1)) |=> (prot_en == $past(cfg_wdata[7]))); // R5
  AST_EN_KEEP: assert property (@(posedge mon_clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == AW'(1)) |=> $stable(prot_en)); // R6

endmodule

bind clkloss_bus_guard clkloss_bus_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .mon_clk     (mon_clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .host_cs_n   (host_cs_n),
  .host_rdy_in (host_rdy_in),
  .host_rdy_out(host_rdy_out),
  .loss_status (loss_status),
  .any_edge    (any_edge),
  .prot_en     (prot_en)
);

// File: tb/clkloss_bus_guard_bench.sv
module clkloss_bus_guard_bench;

  localparam int PERIOD = 10;
  localparam int LIMIT  = 16;

  logic       mon_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       host_cs_n = 1'b1;
  logic       host_rdy_in = 1'b0;
  logic       host_rdy_out;
  logic       loss_status;
  logic       tx_run = 1'b0;
  logic       rx_run = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  clkloss_bus_guard #(.LIMIT(LIMIT)) u_clkloss_bus_guard (
    .mon_clk(mon_clk), .rst_n(rst_n), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .host_cs_n(host_cs_n), .host_rdy_in(host_rdy_in),
    .host_rdy_out(host_rdy_out), .loss_status(loss_status)
  );

  always #(PERIOD/2) mon_clk = ~mon_clk;
  always begin #20; if (tx_run) tx_clk = ~tx_clk; end
  always begin #30; if (rx_run) rx_clk = ~rx_clk; end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(); @(negedge mon_clk); endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(); cfg_we = 1'b0;
  endtask

  // One rising edge on the chosen clock just after a monitor falling edge.
  task automatic pulse(input bit use_rx);
    cyc();
    if (use_rx) begin rx_clk = 1'b0; #1 rx_clk = 1'b1; #1 rx_clk = 1'b0; end
    else        begin tx_clk = 1'b0; #1 tx_clk = 1'b1; #1 tx_clk = 1'b0; end
  endtask

  task automatic go_lost();
    repeat (LIMIT + 3) cyc();
  endtask

  // Expected host ready from the requirements.
  function automatic logic exp_rdy(logic en, logic ls, logic csn, logic rin);
    return rin | (en & ls & ~csn);
  endfunction

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    cyc(); rst_n = 1'b1;
    // R1: reset state
    #1;
    chk("R1 loss after reset", loss_status, 1'b0);
    chk("R1 ready passthrough", host_rdy_out, 1'b0);
    host_cs_n = 1'b0; #1;
    chk("R1 protection disabled", host_rdy_out, 1'b0);
    host_cs_n = 1'b1;

    // R2: exact onset after reset release, both clocks quiet
    for (int j = 1; j <= LIMIT + 3; j++) begin
      cyc(); #1;
      chk($sformatf("R2 onset cycle %0d", j), loss_status, logic'(j >= LIMIT));
    end

    // R4: recovery and re-onset after an edge on each clock
    for (int c = 0; c < 2; c++) begin
      go_lost();
      pulse(c[0]);
      for (int j = 1; j <= LIMIT + 4; j++) begin
        cyc(); #1;
        chk($sformatf("R4 clk%0d cycle %0d", c, j), loss_status,
            logic'(j < 3 || j >= LIMIT + 3));
      end
    end

    // R3: each clock alone keeps the interface normal
    for (int c = 0; c < 2; c++) begin
      go_lost();
      if (c == 0) tx_run = 1'b1; else rx_run = 1'b1;
      repeat (10) cyc();
      for (int j = 0; j < 60; j++) begin
        cyc(); #1;
        chk($sformatf("R3 clk%0d alone", c), loss_status, 1'b0);
      end
      tx_run = 1'b0; rx_run = 1'b0;
      #70;
    end

    // R5/R6: enable bit decoding, observed through forced ready
    go_lost();
    host_cs_n = 1'b0;
    wr(8'h02, 8'hFF); #1;
    chk("R6 other address ignored", host_rdy_out, 1'b0);
    wr(8'h01, 8'h80); #1;
    chk("R5 enable by bit 7", host_rdy_out, 1'b1);
    wr(8'h03, 8'h00); #1;
    chk("R6 other address keeps enable", host_rdy_out, 1'b1);
    wr(8'h01, 8'h7F); #1;
    chk("R5 other bits ignored", host_rdy_out, 1'b0);
    wr(8'h01, 8'hFF); #1;
    chk("R5 re-enable", host_rdy_out, 1'b1);

    // R8: release on chip select high, new cycle forced again
    host_cs_n = 1'b1; #1;
    chk("R8 released when idle", host_rdy_out, 1'b0);
    cyc(); host_cs_n = 1'b0; #1;
    chk("R8 new cycle forced", host_rdy_out, 1'b1);
    chk("R7 loss status", loss_status, 1'b1);
    host_cs_n = 1'b1;

    // R7/R9/R10: sweep enable x loss x chip select x normal ready
    for (int e = 0; e < 2; e++) begin
      wr(8'h01, e[0] ? 8'h80 : 8'h00);
      for (int l = 0; l < 2; l++) begin
        if (l == 1) go_lost();
        else begin pulse(1'b0); repeat (4) cyc(); end
        for (int k = 0; k < 4; k++) begin
          host_cs_n = k[0]; host_rdy_in = k[1]; #1;
          chk($sformatf("R7 R9 R10 sweep e%0d l%0d k%0d", e, l, k), host_rdy_out,
              exp_rdy(e[0], l[0], k[0], k[1]));
        end
        host_cs_n = 1'b1; host_rdy_in = 1'b0;
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule